// File: doc/BRIEF.md
# Dual-Role Pin Strap Latch

This block manages four package pins that serve two purposes in turn. While power comes up the pins are not driven and read as configuration straps. After a fixed settling time the strap values are captured into a holding register. Only after that do the pins switch over to driving clocks.

Each pin has a role:

| Bit | Strap | Clock driven afterwards |
|---|---|---|
| 0 | S0 | 48 MHz clock |
| 1 | S1 | first PCI clock |
| 2 | S2 | second PCI clock |
| 3 | S3 | reference clock |

An undriven strap reads as 0 through the pad pull-down, which lies outside this block.

Settling is counted in system clocks from the first edge at which the power-good input is seen high. It is set by `SETTLE_CYCLES`, which defaults to 3 ms at 50 MHz and must be at least 8. Let `SP = SETTLE_CYCLES / 8`. Each strap is sampled three times and a majority vote of the three forms the latched value.

The latched value is also offered inverted for status readback. It holds until power-good drops. Dropping power-good releases the pins back to input mode and starts the whole sequence again.

All pins are level signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. Power-good is taken as already synchronous to `clk`.

Top module: `dualrole_strap_latch`

## Requirements
- R1: While `rst_n` is low, `strap_done`=0, `pad_oe`=0, `pad_out`=0, `strap_q`=0 and `strap_n`=4'hF, whatever `pwr_good` and `pad_in` are.
- R2: Until the latch step, `pad_oe`, `pad_out` and `strap_q` stay 0 and `strap_done` stays 0.
- R3: Edge 0 is the first rising edge at which `pwr_good` is sampled high. `strap_done` rises at edge `SETTLE_CYCLES`, provided `pwr_good` stays high through edges 0..`SETTLE_CYCLES`.
- R4: Sample k (k=0,1,2) is the value of `pad_in` just before edge `SETTLE_CYCLES-(3-k)*SP`. At the latch edge, each bit of `strap_q` becomes the majority of that bit's three samples.
- R5: The value of `pad_in` at any edge other than the three sample edges has no effect on `strap_q`, both before and after the latch.
- R6: `pad_oe` goes to 4'hF at the edge after the latch edge, never at the latch edge itself. While enabled, `pad_out` equals `clk_src` bit for bit (bit 0 = S0 pin ... bit 3 = S3 pin).
- R7: `strap_n` is always the bitwise inverse of `strap_q`.
- R8: Once `strap_done` is 1, `strap_q` does not change while `pwr_good` stays high.
- R9: An edge with `pwr_good` low clears `strap_done`, `strap_q` and `pad_oe`. The next high `pwr_good` starts a fresh count from edge 0.
- R10: If `pwr_good` drops before the latch edge (including at the latch edge itself), no latch happens and the next sequence latches correct values on the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply settled; low restarts the sequence |
| pad_in | input | NPINS | Input samples from the dual-role pins |
| clk_src | input | NPINS | Clock sources to drive once enabled |
| pad_oe | output | NPINS | Per-pin output-driver enable |
| pad_out | output | NPINS | Per-pin driven value |
| strap_q | output | NPINS | Latched strap values |
| strap_n | output | NPINS | Inverted readback of the latched straps |
| strap_done | output | 1 | Straps have been latched |

## Verification
The bench sweeps every combination of the three sample vectors and places changing noise on `pad_in` at all other edges. A design that votes on the wrong edges, uses fewer samples, or keeps sampling after the latch then shows a wrong `strap_q`. Each run checks the exact edge on which `strap_done` rises and the edge on which the output drivers turn on. An off-by-one counter, or enabling drivers together with the latch, is caught cycle-exactly. Power-good is also dropped one edge before the latch would occur. This exposes a design that still latches, or that resumes the old count instead of restarting.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ARM    = 2'd2,
    ST_DRIVE  = 2'd3
  } strap_state_e;

  localparam int unsigned NSAMP = 3;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/strap_timer.sv
module strap_timer
  import strap_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 150000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  output logic [NSAMP-1:0] sample_stb,
  output logic             latch_stb,
  output logic             drive_en
);
  localparam int unsigned CNT_W   = $clog2(SETTLE_CYCLES + 1);
  localparam int unsigned LAST    = SETTLE_CYCLES - 1;
  localparam int unsigned SPACING = (SETTLE_CYCLES / 8 > 0) ? SETTLE_CYCLES / 8 : 1;

  strap_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_settle;

  assign in_settle = pwr_good && (state_q == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_good) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_SETTLE;
          cnt_q   <= '0;
        end
        ST_SETTLE: begin
          if (cnt_q == CNT_W'(LAST)) state_q <= ST_ARM;
          else                       cnt_q   <= cnt_q + 1'b1;
        end
        ST_ARM:   state_q <= ST_DRIVE;
        default:  state_q <= ST_DRIVE;
      endcase
    end
  end

  // sample points spread evenly over the tail of the settling window
  for (genvar k = 0; k < NSAMP; k++) begin : g_stb
    localparam int unsigned AT = LAST - (NSAMP - k) * SPACING;
    assign sample_stb[k] = in_settle && (cnt_q == CNT_W'(AT));
  end

  assign latch_stb = in_settle && (cnt_q == CNT_W'(LAST));
  assign drive_en  = (state_q == ST_DRIVE);

endmodule

// File: rtl/strap_voter.sv
module strap_voter
  import strap_pkg::*;
#(
  parameter int unsigned NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NSAMP-1:0] sample_stb,
  input  logic             latch_stb,
  output logic [NPINS-1:0] strap_q,
  output logic             done
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [NSAMP-1:0] samp_q;
    logic             bit_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        samp_q <= '0;
        bit_q  <= 1'b0;
      end else begin
        for (int k = 0; k < NSAMP; k++) begin
          if (sample_stb[k]) samp_q[k] <= pad_in[i];
        end
        if (latch_stb) bit_q <= vote3(samp_q[0], samp_q[1], samp_q[2]);
      end
    end

    assign strap_q[i] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) done <= 1'b0;
    else if (latch_stb)  done <= 1'b1;
  end

endmodule

// File: rtl/strap_pad_drive.sv
module strap_pad_drive #(
  parameter int unsigned NPINS = 4
) (
  input  logic             drive_en,
  input  logic [NPINS-1:0] clk_src,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out
);

  for (genvar i = 0; i < NPINS; i++) begin : g_drv
    assign pad_oe[i]  = drive_en;
    assign pad_out[i] = drive_en & clk_src[i];
  end

endmodule

// File: rtl/dualrole_strap_latch.sv
module dualrole_strap_latch
  import strap_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 150000,
  parameter int unsigned NPINS         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] clk_src,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] strap_q,
  output logic [NPINS-1:0] strap_n,
  output logic             strap_done
);
  logic [NSAMP-1:0] sample_stb;
  logic             latch_stb;
  logic             drive_en;

  strap_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .sample_stb (sample_stb),
    .latch_stb  (latch_stb),
    .drive_en   (drive_en)
  );

  strap_voter #(.NPINS(NPINS)) u_voter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (!pwr_good),
    .pad_in     (pad_in),
    .sample_stb (sample_stb),
    .latch_stb  (latch_stb),
    .strap_q    (strap_q),
    .done       (strap_done)
  );

  strap_pad_drive #(.NPINS(NPINS)) u_drive (
    .drive_en (drive_en),
    .clk_src  (clk_src),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out)
  );

  assign strap_n = ~strap_q;

endmodule

// File: rtl/dualrole_strap_latch_chk.sv
module dualrole_strap_latch_chk #(
  parameter int unsigned SETTLE_CYCLES = 150000,
  parameter int unsigned NPINS         = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_good,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] strap_q,
  input logic             strap_done
);
  // consecutive edges with power-good high, saturating
  logic [31:0] pg_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_good) pg_cnt <= '0;
    else if (pg_cnt != '1)   pg_cnt <= pg_cnt + 1'b1;
  end

  assert_latch_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_done) |-> (pg_cnt == 32'(SETTLE_CYCLES + 1)));

  assert_no_drive_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe != '0) |-> strap_done);

  assert_quiet_pads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (pad_out == '0));

  assert_oe_not_with_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_done) |-> (pad_oe == '0));

  assert_oe_after_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strap_done) && pwr_good) |=> (pad_oe == '1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(strap_q));

  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!strap_done && pad_oe == '0 && strap_q == '0));

endmodule

bind dualrole_strap_latch dualrole_strap_latch_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .NPINS        (NPINS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .strap_q    (strap_q),
  .strap_done (strap_done)
);

// File: tb/dualrole_strap_latch_bench.sv
module dualrole_strap_latch_bench;
  localparam int SET = 24;
  localparam int SP  = SET / 8;
  localparam int T0  = SET - 3 * SP;
  localparam int T1  = SET - 2 * SP;
  localparam int T2  = SET - SP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b1;
  logic [3:0] pad_in = 4'hF;
  logic [3:0] clk_src = 4'h0;
  logic [3:0] pad_oe, pad_out, strap_q, strap_n;
  logic       strap_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dualrole_strap_latch #(.SETTLE_CYCLES(SET), .NPINS(4)) u_dualrole_strap_latch (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pad_in(pad_in),
    .clk_src(clk_src), .pad_oe(pad_oe), .pad_out(pad_out),
    .strap_q(strap_q), .strap_n(strap_n), .strap_done(strap_done)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one full sequence; a,b,c are the values at the three sample edges (R4),
  // every other edge carries noise that must be ignored (R5)
  task automatic do_run(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    logic [3:0] want;
    want = (a & b) | (a & c) | (b & c);
    for (int e = 0; e <= SET + 3; e++) begin
      @(negedge clk);
      if (e >= 1) begin
        int past;
        bit latched, driving;
        past    = e - 1;
        latched = (past >= SET);
        driving = (past >= SET + 1);
        chk("R3 done", {3'b0, strap_done}, {3'b0, latched});
        chk(driving ? "R6 oe" : "R2 oe", pad_oe, driving ? 4'hF : 4'h0);
        chk(driving ? "R6 pad_out" : "R2 pad_out", pad_out, driving ? clk_src : 4'h0);
        chk(past == SET ? "R4 R5 strap" : (latched ? "R8 R5 strap" : "R2 strap"),
            strap_q, latched ? want : 4'h0);
        chk("R7 strap_n", strap_n, latched ? ~want : 4'hF);
      end
      pwr_good = 1'b1;
      clk_src  = 4'(e * 3 + 5);
      if (e == T0)      pad_in = a;
      else if (e == T1) pad_in = b;
      else if (e == T2) pad_in = c;
      else              pad_in = 4'(e * 7) ^ ~want;
    end
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R9 done", {3'b0, strap_done}, 4'h0);
    chk("R9 oe", pad_oe, 4'h0);
    chk("R9 strap", strap_q, 4'h0);
  endtask

  // power-good high for len edges, then dropped (R10)
  task automatic abort_run(input int len);
    for (int e = 0; e < len; e++) begin
      @(negedge clk);
      pwr_good = 1'b1;
      pad_in   = 4'hF;
    end
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R10 done", {3'b0, strap_done}, 4'h0);
    chk("R10 strap", strap_q, 4'h0);
    chk("R10 oe", pad_oe, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", {3'b0, strap_done}, 4'h0);
    chk("R1 oe", pad_oe, 4'h0);
    chk("R1 pad_out", pad_out, 4'h0);
    chk("R1 strap", strap_q, 4'h0);
    chk("R1 strap_n", strap_n, 4'hF);
    pwr_good = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);

    for (int idx = 0; idx < 4096; idx++) begin
      do_run(4'(idx), 4'(idx >> 4), 4'(idx >> 8));
    end

    abort_run(SET);
    do_run(4'hF, 4'hF, 4'h0);
    abort_run(T1);
    do_run(4'h0, 4'h5, 4'h5);
    abort_run(SET - 1);
    do_run(4'hA, 4'h3, 4'h6);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule